// File: doc/BRIEF.md
# Stereo DC-Removal Post Filter

This block removes the slowly varying offset from a stereo stream of 24-bit signed samples. For each channel it keeps a running estimate of the low-frequency content with a first-order leaky integrator. On every sample strobe it subtracts that estimate from the incoming sample and returns the difference, clamped to the 24-bit range. The integrator's leak factor sets the corner frequency. A 5-bit cutoff code picks it: code 0 gives a very low corner of about 3.7 Hz for plain offset removal. Codes 1 to 16 give 50 Hz times the code, and larger codes stay at 800 Hz. All of these figures assume a 48 kHz sample rate and move in proportion at other rates.

An 8-bit control word sets how the block behaves. Bits [1:0] enable the left and right filters on their own. Bit 2 sets what a disabled channel does with its estimate: it either freezes the estimate and keeps subtracting it, or it clears the estimate so the samples pass through unchanged. Bits [7:3] carry the cutoff code. A new cutoff code acts on the next strobe and leaves the current estimate in place.

Top module: `dcf_post_filter`

## Requirements
- R1: A synchronous reset clears out_valid, both outputs and both internal estimates. The first enabled sample after reset is therefore returned unchanged.
- R2: out_valid is high in the cycle after in_valid and low otherwise. The outputs change only in the cycle after a strobe.
- R3: Each output is x minus floor(estimate / 2^16), clamped to the range -8388608 to 8388607.
- R4: On a strobe of an enabled channel the estimate E, held in units of 2^-16 of an input LSB, becomes E + floor(((x·2^16 − E)·C) / 2^16). C is 32 for code 0, 429 times the code for codes 1 to 16, and 6864 for codes 17 to 31. The code is ctrl[7:3].
- R5: ctrl[0] enables the left channel and ctrl[1] enables the right channel, each on its own.
- R6: With a channel disabled and ctrl[2]=1, its estimate stays frozen and is still subtracted from each sample.
- R7: With a channel disabled and ctrl[2]=0, its estimate is zero from the next clock on, and its output equals its input.
- R8: A change of the cutoff code applies to the update made at the next strobe and does not reset the estimate.
- R9: When a channel is enabled again after a frozen period, it goes on updating from the frozen estimate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 8 | [7:3] cutoff code, [2] keep estimate when disabled, [1] right enable, [0] left enable |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_left | output | 24 | Left filtered sample, signed |
| out_right | output | 24 | Right filtered sample, signed |

## Verification
Output saturation is the hardest state to reach, because it needs an estimate close to one rail followed by a sample at the other rail. To reach it, the stimulus drives full-scale inputs of opposite sign on the two channels for a few hundred strobes at the fastest cutoff code, so both estimates settle close to the rails. It then swaps the signs, which forces both clamps in a single step. The frozen-then-resumed path is also driven on purpose: the bench holds a channel while its input swings, then enables it again.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   // control word layout
   localparam int DCF_EN_L_BIT  = 0;
   localparam int DCF_EN_R_BIT  = 1;
   localparam int DCF_KEEP_BIT  = 2;
   localparam int DCF_CODE_LSB  = 3;
   localparam int DCF_NUM_CH    = 2;

   // saturate a signed value of width w to a narrower signed width n (as 64-bit ints)
   function automatic longint dcf_max_of(input int n);
      return (longint'(1) <<< (n - 1)) - 1;
   endfunction

   function automatic longint dcf_min_of(input int n);
      return -(longint'(1) <<< (n - 1));
   endfunction
endpackage

// File: rtl/dcf_coef.sv
module dcf_coef #(
   parameter int CODE_W    = 5,
   parameter int COEF_W    = 16,
   parameter int MAX_CODE  = 16,
   parameter int STEP_COEF = 429,
   parameter int DC_COEF   = 32,
   parameter bit POW2_ONLY = 1'b0
) (
   input  logic [CODE_W-1:0] code,
   output logic [COEF_W-1:0] coef
);
   localparam int TOP_COEF = MAX_CODE * STEP_COEF;

   if (TOP_COEF >= (1 << COEF_W)) begin : g_bad_coef
      $error("dcf_coef: largest coefficient does not fit COEF_W");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("dcf_coef: MAX_CODE not reachable with CODE_W bits");
   end

   logic [COEF_W-1:0] lin;

   always_comb begin
      if (code == '0)
         lin = COEF_W'(DC_COEF);
      else if (int'(code) > MAX_CODE)
         lin = COEF_W'(TOP_COEF);
      else
         lin = COEF_W'(int'(code) * STEP_COEF);
   end

   if (POW2_ONLY) begin : g_pow2
      // coefficient rounded down to a power of two: multiplier becomes a shifter
      logic [COEF_W-1:0] p2;
      always_comb begin
         p2 = '0;
         for (int i = 0; i < COEF_W; i++)
            if (lin[i]) p2 = COEF_W'(1) << i;
      end
      assign coef = p2;
   end else begin : g_linear
      assign coef = lin;
   end
endmodule

// File: rtl/dcf_sat.sv
module dcf_sat #(
   parameter int IN_W  = 26,
   parameter int OUT_W = 24
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   if (IN_W <= OUT_W) begin : g_bad
      $error("dcf_sat: IN_W must exceed OUT_W");
   end

   localparam logic signed [IN_W-1:0] HI = IN_W'((longint'(1) <<< (OUT_W - 1)) - 1);
   localparam logic signed [IN_W-1:0] LO = IN_W'(-(longint'(1) <<< (OUT_W - 1)));

   always_comb begin
      if (din > HI)
         dout = HI[OUT_W-1:0];
      else if (din < LO)
         dout = LO[OUT_W-1:0];
      else
         dout = din[OUT_W-1:0];
   end
endmodule

// File: rtl/dcf_chan.sv
module dcf_chan #(
   parameter int DATA_W = 24,
   parameter int FRAC_W = 16,
   parameter int COEF_W = 16,
   localparam int EST_W = DATA_W + FRAC_W + 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     strobe,
   input  logic                     en,
   input  logic                     keep,
   input  logic [COEF_W-1:0]        coef,
   input  logic signed [DATA_W-1:0] x,
   output logic signed [DATA_W-1:0] y,
   output logic signed [EST_W-1:0]  est_o
);
   localparam int DIFF_W = EST_W + 1;
   localparam int PROD_W = DIFF_W + COEF_W + 1;
   localparam int INT_W  = EST_W - FRAC_W;

   if (FRAC_W < COEF_W) begin : g_bad_frac
      $error("dcf_chan: FRAC_W must be at least COEF_W to avoid a stuck estimate");
   end

   logic signed [EST_W-1:0]  est_q;
   logic signed [EST_W-1:0]  est_eff;
   logic signed [EST_W-1:0]  x_fix;
   logic signed [DIFF_W-1:0] diff;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] step;
   logic signed [EST_W-1:0]  est_next;
   logic signed [INT_W-1:0]  resid;
   logic signed [DATA_W-1:0] y_sat;

   // sample placed on the estimator's fixed-point grid
   assign x_fix = {{(EST_W-DATA_W-FRAC_W){x[DATA_W-1]}}, x, {FRAC_W{1'b0}}};

   // leaky integrator update
   assign diff     = {x_fix[EST_W-1], x_fix} - {est_q[EST_W-1], est_q};
   assign prod     = diff * $signed({1'b0, coef});
   assign step     = prod >>> COEF_W;
   assign est_next = est_q + step[EST_W-1:0];

   // estimate seen by the subtractor: zero while cleared
   assign est_eff = (en || keep) ? est_q : '0;

   assign resid = {{(INT_W-DATA_W){x[DATA_W-1]}}, x} - est_eff[EST_W-1:FRAC_W];

   dcf_sat #(.IN_W(INT_W), .OUT_W(DATA_W)) u_sat (
      .din  (resid),
      .dout (y_sat)
   );

   always_ff @(posedge clk) begin
      if (rst)
         est_q <= '0;
      else if (en && strobe)
         est_q <= est_next;
      else if (!en && !keep)
         est_q <= '0;
   end

   always_ff @(posedge clk) begin
      if (rst)
         y <= '0;
      else if (strobe)
         y <= y_sat;
   end

   assign est_o = est_q;
endmodule

// File: rtl/dcf_post_filter.sv
module dcf_post_filter #(
   parameter int DATA_W    = 24,
   parameter int CODE_W    = 5,
   parameter int FRAC_W    = 16,
   parameter int COEF_W    = 16,
   parameter int MAX_CODE  = 16,
   parameter int STEP_COEF = 429,
   parameter int DC_COEF   = 32,
   parameter bit POW2_ONLY = 1'b0,
   localparam int CTRL_W   = dcf_pkg::DCF_CODE_LSB + CODE_W,
   localparam int EST_W    = DATA_W + FRAC_W + 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [CTRL_W-1:0]        ctrl,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_left,
   input  logic signed [DATA_W-1:0] in_right,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_left,
   output logic signed [DATA_W-1:0] out_right
);
   import dcf_pkg::*;

   if (DATA_W < 8) begin : g_bad_width
      $error("dcf_post_filter: DATA_W too small");
   end

   logic [COEF_W-1:0]        coef;
   logic signed [DATA_W-1:0] x_arr [DCF_NUM_CH];
   logic signed [DATA_W-1:0] y_arr [DCF_NUM_CH];
   logic signed [EST_W-1:0]  est_w [DCF_NUM_CH];

   assign x_arr[0] = in_left;
   assign x_arr[1] = in_right;

   dcf_coef #(
      .CODE_W    (CODE_W),
      .COEF_W    (COEF_W),
      .MAX_CODE  (MAX_CODE),
      .STEP_COEF (STEP_COEF),
      .DC_COEF   (DC_COEF),
      .POW2_ONLY (POW2_ONLY)
   ) u_coef (
      .code (ctrl[CTRL_W-1:DCF_CODE_LSB]),
      .coef (coef)
   );

   for (genvar ch = 0; ch < DCF_NUM_CH; ch++) begin : g_ch
      dcf_chan #(
         .DATA_W (DATA_W),
         .FRAC_W (FRAC_W),
         .COEF_W (COEF_W)
      ) u_chan (
         .clk    (clk),
         .rst    (rst),
         .strobe (in_valid),
         .en     (ctrl[DCF_EN_L_BIT + ch]),
         .keep   (ctrl[DCF_KEEP_BIT]),
         .coef   (coef),
         .x      (x_arr[ch]),
         .y      (y_arr[ch]),
         .est_o  (est_w[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)
         out_valid <= 1'b0;
      else
         out_valid <= in_valid;
   end

   assign out_left  = y_arr[0];
   assign out_right = y_arr[1];
endmodule

// File: rtl/dcf_post_filter_chk.sv
module dcf_post_filter_chk #(
   parameter int DATA_W = 24,
   parameter int CTRL_W = 8,
   parameter int EST_W  = 42
) (
   input logic                     clk,
   input logic                     rst,
   input logic [CTRL_W-1:0]        ctrl,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] in_left,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_left,
   input logic signed [DATA_W-1:0] out_right,
   input logic signed [EST_W-1:0]  est_l,
   input logic signed [EST_W-1:0]  est_r
);
   p_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_left == '0 && out_right == '0));

   p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

   p_right_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[1] && !ctrl[2]) |=> est_r == '0);

   p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[0] && ctrl[2]) |=> $stable(est_l));

   p_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[0] && !ctrl[2]) |=> est_l == '0);

   p_pass_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ctrl[0] && !ctrl[2]) |=> out_left == $past(in_left));
endmodule

bind dcf_post_filter dcf_post_filter_chk #(
   .DATA_W (DATA_W),
   .CTRL_W (CTRL_W),
   .EST_W  (EST_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ctrl      (ctrl),
   .in_valid  (in_valid),
   .in_left   (in_left),
   .out_valid (out_valid),
   .out_left  (out_left),
   .out_right (out_right),
   .est_l     (est_w[0]),
   .est_r     (est_w[1])
);

// File: tb/dcf_post_filter_test.sv
module dcf_post_filter_test;
   localparam int CLK_PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [7:0]         ctrl = '0;
   logic               in_valid = 1'b0;
   logic signed [23:0] in_left = '0;
   logic signed [23:0] in_right = '0;
   logic               out_valid;
   logic signed [23:0] out_left;
   logic signed [23:0] out_right;

   int checks = 0;
   int failures = 0;
   string req = "R1";

   longint est [2];
   longint yexp [2];
   bit     vexp;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcf_post_filter uut (
      .clk       (clk),
      .rst       (rst),
      .ctrl      (ctrl),
      .in_valid  (in_valid),
      .in_left   (in_left),
      .in_right  (in_right),
      .out_valid (out_valid),
      .out_left  (out_left),
      .out_right (out_right)
   );

   function automatic longint sat24(input longint v);
      if (v > 8388607) return 8388607;
      if (v < -8388608) return -8388608;
      return v;
   endfunction

   function automatic longint coef_of(input int code);
      if (code == 0) return 32;
      if (code > 16) return 6864;
      return 429 * code;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input bit v, input longint l, input longint r, input logic [7:0] c);
      longint x, eff;
      in_valid = v;
      in_left  = l[23:0];
      in_right = r[23:0];
      ctrl     = c;
      @(negedge clk);
      for (int ch = 0; ch < 2; ch++) begin
         x   = (ch == 0) ? l : r;
         eff = (c[ch] || c[2]) ? est[ch] : 0;
         if (v) yexp[ch] = sat24(x - (eff >>> 16));
         if (c[ch] && v)
            est[ch] = est[ch] + ((((x <<< 16) - est[ch]) * coef_of(int'(c[7:3]))) >>> 16);
         else if (!c[ch] && !c[2])
            est[ch] = 0;
      end
      vexp = v;
      check({req, " valid"}, longint'(out_valid), longint'(vexp));
      check({req, " left"},  longint'(out_left),  yexp[0]);
      check({req, " right"}, longint'(out_right), yexp[1]);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      est[0] = 0; est[1] = 0; yexp[0] = 0; yexp[1] = 0; vexp = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check("R1 valid", longint'(out_valid), 0);
      check("R1 left",  longint'(out_left), 0);
      check("R1 right", longint'(out_right), 0);
      step(1'b1, 123456, -654321, {5'd16, 3'b011});
      check("R1 first passthrough", longint'(out_left), 123456);

      req = "R4";
      for (int i = 0; i < 60; i++)
         step(1'b1, 1000000 + (i % 7) * 1000, -2000000 + (i % 5) * 300, {5'd16, 3'b011});

      req = "R8";
      for (int i = 0; i < 20; i++) step(1'b1, 50000 - i * 900, 7000 + i, {5'd0, 3'b011});
      for (int i = 0; i < 20; i++) step(1'b1, -30000 + i * 1500, 9000, {5'd5, 3'b011});
      for (int i = 0; i < 20; i++) step(1'b1, 400000, -i * 2500, {5'd31, 3'b011});

      req = "R2";
      for (int i = 0; i < 30; i++)
         step(i % 3 == 0, 250000 + i * 111, -90000 - i * 77, {5'd9, 3'b011});

      req = "R5";
      for (int i = 0; i < 20; i++) step(1'b1, 600000 + i, -300000 + i * 40, {5'd12, 3'b001});

      req = "R6";
      for (int i = 0; i < 20; i++)
         step(1'b1, (i % 2 == 0) ? 3000000 : -3000000, 200000 - i * 10000, {5'd16, 3'b100});

      req = "R9";
      for (int i = 0; i < 20; i++) step(1'b1, 150000, -150000, {5'd16, 3'b011});

      req = "R7";
      for (int i = 0; i < 10; i++) begin
         step(1'b1, 777000 - i * 5000, -i * 1234, {5'd16, 3'b000});
         check("R7 left equals input", longint'(out_left), 777000 - i * 5000);
         check("R7 right equals input", longint'(out_right), -i * 1234);
      end

      req = "R3";
      for (int i = 0; i < 250; i++) step(1'b1, 8388607, -8388608, {5'd16, 3'b011});
      step(1'b1, -8388608, 8388607, {5'd16, 3'b011});
      check("R3 left clamps low", longint'(out_left), -8388608);
      check("R3 right clamps high", longint'(out_right), 8388607);
      for (int i = 0; i < 5; i++) step(1'b0, 0, 0, {5'd16, 3'b011});

      summary();
      $finish;
   end
endmodule